// File: doc/BRIEF.md
# Self-Synchronizing Serial Scrambler and Descrambler

This block holds a transmit lane that scrambles and a receive lane that descrambles a serial bit stream, one bit per clock, with the polynomial x^N + 1. N is the delay length and defaults to 43. The transmit lane combines each payload bit by XOR with the bit it sent N payload positions earlier. The receive lane combines each arriving bit by XOR with the bit it received N payload positions earlier. The receiver therefore locks on the line data itself, and no seed has to be exchanged. Its output is correct from the (N+1)-th payload bit on, whatever its delay line held at the start.

Each lane marks a bit as header with a bypass input. A header bit crosses the lane unscrambled and leaves the delay line untouched. A cycle with the valid input low also leaves the delay line untouched. The result bit is combinational in the same cycle as its input, with no pipeline stage between the XOR and the delay line. A parameter inverts every transmitted line bit, and the receive lane removes that inversion again at its input. A synchronous reset loads a seed port into each delay line.

Top module: `sss_codec`

## Requirements
- R1: `tx_out_valid` equals `tx_in_valid` in the same cycle. For a valid payload bit, `tx_out_bit` is `tx_in_bit` XOR the oldest delay-line stage, further XORed with INVERT_LINE, all in that same cycle.
- R2: After each valid payload bit, the transmit delay line shifts in the scrambled bit it produced, taken before line inversion, and not the plaintext bit.
- R3: `rx_out_valid` equals `rx_in_valid`. For a valid payload bit, `rx_out_bit` is (`rx_in_bit` XOR INVERT_LINE) XOR the oldest receive stage, and that un-inverted received bit is what the receive delay line shifts in.
- R4: While `rst` is high at a clock edge, each delay line loads its seed port. Bit N-1 of the seed is the oldest stage, so the k-th payload bit after reset (k from 0 to N-1) is combined with seed bit N-1-k.
- R5: With a transmit seed of all zeros, the first N payload bits after reset leave the transmit lane unchanged, apart from line inversion.
- R6: Whatever seeds the two lanes hold, a receive lane fed by the transmit lane returns the original data from payload bit N onward, counting from 0.
- R7: A valid bit with bypass high leaves as its input. On the transmit side it is XORed with INVERT_LINE; on the receive side the inversion is removed. Neither delay line advances.
- R8: A cycle with the valid input low advances no delay line and drives the valid output low.
- R9: With INVERT_LINE = 1, every transmitted bit is the complement of the INVERT_LINE = 0 result, and the loopback still returns the original data.
- R10: An instance with DELAY_LEN = 4 scrambles and recovers by the same rules, with N = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; loads the seeds |
| tx_seed | input | DELAY_LEN | Seed for the transmit delay line |
| rx_seed | input | DELAY_LEN | Seed for the receive delay line |
| tx_in_valid | input | 1 | Transmit input bit present |
| tx_in_bit | input | 1 | Plaintext bit |
| tx_bypass | input | 1 | Current transmit bit is header |
| tx_out_valid | output | 1 | Transmit output bit present |
| tx_out_bit | output | 1 | Line bit |
| rx_in_valid | input | 1 | Receive input bit present |
| rx_in_bit | input | 1 | Line bit received |
| rx_bypass | input | 1 | Current received bit is header |
| rx_out_valid | output | 1 | Receive output bit present |
| rx_out_bit | output | 1 | Recovered bit |

## Verification
The result bit and the valid output are due in the same cycle as the input bit. The effect of that bit on the delay line appears only in the results of later payload bits, N payload positions on. The bench drives each input on the falling edge and samples the outputs one nanosecond later, before the next rising edge, so it sees both the combinational result and the state that the previous edge left. It predicts every result from its own record of the bits sent since reset, indexed by payload position. Header and idle cycles are excluded from that count, so a delay line that advanced on them would show up as a wrong bit N positions later.

// File: rtl/sss_pkg.sv
package sss_pkg;

  typedef enum logic {
    LANE_SCRAMBLE   = 1'b0,
    LANE_DESCRAMBLE = 1'b1
  } lane_dir_e;

  // one tap combine of the x^N+1 code
  function automatic logic tap_mix(input logic data_b, input logic tap_b);
    return data_b ^ tap_b;
  endfunction

  // optional line polarity
  function automatic logic line_pol(input logic b, input logic inv);
    return b ^ inv;
  endfunction

endpackage

// File: rtl/sss_delay_line.sv
module sss_delay_line #(
  parameter int LEN = 43
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LEN-1:0] seed,
  input  logic           shift_en,
  input  logic           din,
  output logic           tap,
  output logic           head
);
  logic [LEN-1:0] q;

  generate
    if (LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           q <= seed;
        else if (shift_en) q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)           q <= seed;
        else if (shift_en) q <= {q[LEN-2:0], din};
      end
    end
  endgenerate

  assign tap  = q[LEN-1];
  assign head = q[0];
endmodule

// File: rtl/sss_lane.sv
module sss_lane
  import sss_pkg::*;
#(
  parameter int        LEN    = 43,
  parameter lane_dir_e DIR    = LANE_SCRAMBLE,
  parameter bit        INVERT = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LEN-1:0] seed,
  input  logic           in_valid,
  input  logic           in_bit,
  input  logic           bypass,
  output logic           out_valid,
  output logic           out_bit,
  output logic           shift_en,
  output logic           tap,
  output logic           head
);
  logic pre_bit;   // input after removing line polarity (receive only)
  logic core_bit;  // scrambled or recovered bit, before line polarity
  logic feed_bit;  // bit that enters the delay line
  logic post_bit;  // bit after line polarity (transmit only)

  assign shift_en = in_valid & ~bypass;

  generate
    if (DIR == LANE_DESCRAMBLE) begin : g_rx
      assign pre_bit  = line_pol(in_bit, INVERT);
      assign core_bit = bypass ? pre_bit : tap_mix(pre_bit, tap);
      assign feed_bit = pre_bit;
      assign post_bit = core_bit;
    end else begin : g_tx
      assign pre_bit  = in_bit;
      assign core_bit = bypass ? pre_bit : tap_mix(pre_bit, tap);
      assign feed_bit = core_bit;
      assign post_bit = line_pol(core_bit, INVERT);
    end
  endgenerate

  sss_delay_line #(.LEN(LEN)) u_line (
    .clk      (clk),
    .rst      (rst),
    .seed     (seed),
    .shift_en (shift_en),
    .din      (feed_bit),
    .tap      (tap),
    .head     (head)
  );

  assign out_valid = in_valid;
  assign out_bit   = in_valid ? post_bit : 1'b0;
endmodule

// File: rtl/sss_codec.sv
module sss_codec
  import sss_pkg::*;
#(
  parameter int DELAY_LEN   = 43,
  parameter bit INVERT_LINE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DELAY_LEN-1:0] tx_seed,
  input  logic [DELAY_LEN-1:0] rx_seed,
  input  logic                 tx_in_valid,
  input  logic                 tx_in_bit,
  input  logic                 tx_bypass,
  output logic                 tx_out_valid,
  output logic                 tx_out_bit,
  input  logic                 rx_in_valid,
  input  logic                 rx_in_bit,
  input  logic                 rx_bypass,
  output logic                 rx_out_valid,
  output logic                 rx_out_bit
);
  // internal events brought out for the checker
  logic tx_shift_en, tx_tap, tx_head;
  logic rx_shift_en, rx_tap, rx_head;

  sss_lane #(.LEN(DELAY_LEN), .DIR(LANE_SCRAMBLE), .INVERT(INVERT_LINE)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .seed      (tx_seed),
    .in_valid  (tx_in_valid),
    .in_bit    (tx_in_bit),
    .bypass    (tx_bypass),
    .out_valid (tx_out_valid),
    .out_bit   (tx_out_bit),
    .shift_en  (tx_shift_en),
    .tap       (tx_tap),
    .head      (tx_head)
  );

  sss_lane #(.LEN(DELAY_LEN), .DIR(LANE_DESCRAMBLE), .INVERT(INVERT_LINE)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .seed      (rx_seed),
    .in_valid  (rx_in_valid),
    .in_bit    (rx_in_bit),
    .bypass    (rx_bypass),
    .out_valid (rx_out_valid),
    .out_bit   (rx_out_bit),
    .shift_en  (rx_shift_en),
    .tap       (rx_tap),
    .head      (rx_head)
  );
endmodule

// File: rtl/sss_codec_chk.sv
module sss_codec_chk #(
  parameter int DELAY_LEN   = 43,
  parameter bit INVERT_LINE = 1'b0
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DELAY_LEN-1:0] tx_seed,
  input logic [DELAY_LEN-1:0] rx_seed,
  input logic                 tx_in_valid,
  input logic                 tx_in_bit,
  input logic                 tx_bypass,
  input logic                 tx_out_valid,
  input logic                 tx_out_bit,
  input logic                 rx_in_valid,
  input logic                 rx_in_bit,
  input logic                 rx_bypass,
  input logic                 rx_out_valid,
  input logic                 tx_shift_en,
  input logic                 tx_tap,
  input logic                 tx_head,
  input logic                 rx_shift_en,
  input logic                 rx_tap,
  input logic                 rx_head
);
  p_tx_valid_r1: assert property (@(posedge clk) disable iff (rst)
    tx_out_valid == tx_in_valid);

  p_tx_feed_r2: assert property (@(posedge clk) disable iff (rst)
    tx_shift_en |=> tx_head == ($past(tx_out_bit) ^ INVERT_LINE));

  p_rx_valid_r3: assert property (@(posedge clk) disable iff (rst)
    rx_out_valid == rx_in_valid);

  p_rx_feed_r3: assert property (@(posedge clk) disable iff (rst)
    rx_shift_en |=> rx_head == ($past(rx_in_bit) ^ INVERT_LINE));

  p_seed_tx_r4: assert property (@(posedge clk)
    rst |=> tx_tap == $past(tx_seed[DELAY_LEN-1]));

  p_seed_rx_r4: assert property (@(posedge clk)
    rst |=> rx_tap == $past(rx_seed[DELAY_LEN-1]));

  p_tx_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_in_valid && tx_bypass) |-> (tx_out_bit == (tx_in_bit ^ INVERT_LINE)) && !tx_shift_en);

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !tx_in_valid |=> $stable(tx_tap) && $stable(tx_head));

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rx_in_valid |=> $stable(rx_tap) && $stable(rx_head));
endmodule

bind sss_codec sss_codec_chk #(.DELAY_LEN(DELAY_LEN), .INVERT_LINE(INVERT_LINE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_seed      (tx_seed),
  .rx_seed      (rx_seed),
  .tx_in_valid  (tx_in_valid),
  .tx_in_bit    (tx_in_bit),
  .tx_bypass    (tx_bypass),
  .tx_out_valid (tx_out_valid),
  .tx_out_bit   (tx_out_bit),
  .rx_in_valid  (rx_in_valid),
  .rx_in_bit    (rx_in_bit),
  .rx_bypass    (rx_bypass),
  .rx_out_valid (rx_out_valid),
  .tx_shift_en  (tx_shift_en),
  .tx_tap       (tx_tap),
  .tx_head      (tx_head),
  .rx_shift_en  (rx_shift_en),
  .rx_tap       (rx_tap),
  .rx_head      (rx_head)
);

// File: tb/tb_sss_codec.sv
module tb_sss_codec;
  localparam int NA = 43;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic v, d, byp;
  logic [NA-1:0] seed_a_tx, seed_a_rx;
  logic [NB-1:0] seed_b_tx, seed_b_rx;

  logic a_tov, a_tob, a_rov, a_rob;
  logic b_tov, b_tob, b_rov, b_rob;

  // dut: 43 stages, no inversion, looped back
  sss_codec #(.DELAY_LEN(NA), .INVERT_LINE(1'b0)) dut (
    .clk(clk), .rst(rst), .tx_seed(seed_a_tx), .rx_seed(seed_a_rx),
    .tx_in_valid(v), .tx_in_bit(d), .tx_bypass(byp),
    .tx_out_valid(a_tov), .tx_out_bit(a_tob),
    .rx_in_valid(a_tov), .rx_in_bit(a_tob), .rx_bypass(byp),
    .rx_out_valid(a_rov), .rx_out_bit(a_rob));

  // second instance: 4 stages, inverted line, looped back
  sss_codec #(.DELAY_LEN(NB), .INVERT_LINE(1'b1)) dut4 (
    .clk(clk), .rst(rst), .tx_seed(seed_b_tx), .rx_seed(seed_b_rx),
    .tx_in_valid(v), .tx_in_bit(d), .tx_bypass(byp),
    .tx_out_valid(b_tov), .tx_out_bit(b_tob),
    .rx_in_valid(b_tov), .rx_in_bit(b_tob), .rx_bypass(byp),
    .rx_out_valid(b_rov), .rx_out_bit(b_rob));

  int checks = 0;
  int errors = 0;
  int j;             // payload index since reset
  logic sa [0:1023]; // scrambled history, 43-stage instance
  logic sb [0:1023]; // scrambled history, 4-stage instance
  bit zero_seed;

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [NA-1:0] ta, input logic [NA-1:0] ra,
                          input logic [NB-1:0] tb, input logic [NB-1:0] rb);
    @(negedge clk);
    rst = 1'b1; v = 1'b0; d = 1'b0; byp = 1'b0;
    seed_a_tx = ta; seed_a_rx = ra; seed_b_tx = tb; seed_b_rx = rb;
    zero_seed = (ta == '0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    j = 0;
  endtask

  task automatic step(input logic vi, input logic di, input logic bi);
    logic ea, eb, ra, rb2;
    @(negedge clk);
    v = vi; d = di; byp = bi;
    #1;
    if (!vi) begin
      chk(a_tov == 1'b0, "R8 tx valid low", a_tov, 1'b0);
      chk(a_rov == 1'b0, "R8 rx valid low", a_rov, 1'b0);
      chk(b_tov == 1'b0, "R8 tx4 valid low", b_tov, 1'b0);
    end else if (bi) begin
      chk(a_tob == di, "R7 tx header", a_tob, di);
      chk(a_rob == di, "R7 rx header", a_rob, di);
      chk(b_tob == ~di, "R7 R9 tx4 header", b_tob, ~di);
      chk(b_rob == di, "R7 rx4 header", b_rob, di);
    end else begin
      chk(a_tov == 1'b1, "R1 tx valid", a_tov, 1'b1);
      chk(a_rov == 1'b1, "R3 rx valid", a_rov, 1'b1);
      // R1 R2 R4: s[k] = d[k] ^ (k>=N ? s[k-N] : seed[N-1-k])
      ea = di ^ ((j >= NA) ? sa[j-NA] : seed_a_tx[NA-1-j]);
      eb = di ^ ((j >= NB) ? sb[j-NB] : seed_b_tx[NB-1-j]);
      sa[j] = ea; sb[j] = eb;
      chk(a_tob == ea, "R1 R2 R4 tx bit", a_tob, ea);
      chk(b_tob == ~eb, "R9 R10 tx4 bit", b_tob, ~eb);
      if (zero_seed && j < NA) chk(a_tob == di, "R5 pass-through", a_tob, di);
      // R3: recovered = s[k] ^ (k>=N ? s[k-N] : rxseed[N-1-k])
      ra  = ea ^ ((j >= NA) ? sa[j-NA] : seed_a_rx[NA-1-j]);
      rb2 = eb ^ ((j >= NB) ? sb[j-NB] : seed_b_rx[NB-1-j]);
      chk(a_rob == ra, "R3 rx bit", a_rob, ra);
      chk(b_rob == rb2, "R3 R10 rx4 bit", b_rob, rb2);
      if (j >= NA) chk(a_rob == di, "R6 lock", a_rob, di);
      if (j >= NB) chk(b_rob == di, "R6 R9 R10 lock4", b_rob, di);
      j++;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    v = 1'b0; d = 1'b0; byp = 1'b0;
    seed_a_tx = '0; seed_a_rx = '0; seed_b_tx = '0; seed_b_rx = '0;
    zero_seed = 1'b1; j = 0;

    // phase A: zero transmit seed, foreign receive seed
    do_reset('0, 43'h5A5_F0F0_A55A, 4'b0000, 4'b1011);
    step(1'b0, 1'b1, 1'b0);   // reset state: idle outputs
    for (int i = 0; i < 8; i++) step(1'b1, 1'($urandom), 1'b1); // header
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 120; i++) step(1'b1, 1'b1, 1'b0); // all-ones run
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom % 10);
      step(r != 0, 1'($urandom), r == 1);
    end

    // phase B: nonzero seeds on both sides
    do_reset(43'h7FF_0000_1234, 43'h123_4567_89AB, 4'b1001, 4'b0110);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 1'b0); // zeros expose seed
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom % 8);
      step(r != 0, 1'($urandom), r == 2);
    end

    // phase C: identical seeds, alternating pattern
    do_reset(43'h0AA_AAAA_AAAA, 43'h0AA_AAAA_AAAA, 4'b1111, 4'b1111);
    for (int i = 0; i < 150; i++) step(1'b1, 1'(i % 2), 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule